// File: doc/BRIEF.md
# Watchdog Timer with Reset Cause

This block is a watchdog that counts ticks of a slow internal time base and pulls the system reset when software stops servicing it. Software restarts the count by writing a fixed key value to a clear strobe. A two-bit mode input selects how the watchdog behaves. It can be off. It can run but freeze while the chip sleeps in power-down or green mode. Or it can keep running through sleep and reset the chip from there.

Every reset the block issues is held for a fixed number of slow ticks and then released. A two-bit cause code records what last reset the system: the watchdog, a power-on or low-voltage event, or the external reset pin. Software reads this code after start-up.

The control is a four-state machine:
- `ST_RUN`: counting.
- `ST_PAUSE`: frozen while sleeping in the stop-in-sleep mode.
- `ST_OFF`: disabled, counter held at zero.
- `ST_HOLD`: system reset asserted.

The named transitions are:
- run-to-hold on overflow ("fire").
- any-to-hold on the external pin.
- run-to-pause on sleep entry, and pause-to-run on sleep exit or a switch to the keep-running mode.
- run/pause-to-off on disable, and off-to-run/pause on enable.
- hold-to-run/pause/off ("release") once the hold window has elapsed.

Top module: `wdog_rstcause`

## Requirements
- R1: With counting enabled and no valid clear, the system reset asserts on the clock after the 2^CNT_W-th counted tick (64 with defaults) since the count last started from zero, and the cause code becomes 00.
- R2: Cause code values are 00 for watchdog overflow, 10 for power-on/low-voltage reset and 11 for the external pin; code 01 is reserved and never produced.
- R3: A high external reset request asserts the system reset on the next clock edge, sets the cause to 11, clears the count and keeps the reset asserted while the request stays high.
- R4: In mode 01 (stop in sleep), while the low-power input is high the count holds its value, and no watchdog reset occurs however long sleep lasts; counting resumes from the held value on wake.
- R5: In modes 10 and 11 (keep running), the count continues while the low-power input is high and an overflow resets the system from sleep.
- R6: A clear-strobe write whose 8-bit data equals 0x5A restarts the count from zero; this takes priority over a tick and over an overflow in the same cycle.
- R7: A clear-strobe write with any data other than 0x5A has no effect on the count.
- R8: After its cause is removed, the system reset stays asserted for exactly HOLD_TICKS slow ticks (4 by default) and then releases, with the count starting from zero.
- R9: In mode 00 (disabled) the count is held at zero and no watchdog reset is ever asserted; enabling later starts counting from zero.
- R10: The power-on/low-voltage reset input acts asynchronously: it asserts the system reset at once, sets the cause to 10 and clears the count and hold timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_rst | input | 1 | Power-on / low-voltage reset request, asynchronous, active high |
| ext_rst | input | 1 | External reset pin request, synchronous, active high |
| tick | input | 1 | One-cycle enable marking a slow-clock tick |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_data | input | KEY_W (8) | Data of the clear-register write |
| wd_mode | input | 2 | 00 disabled, 01 stop in sleep, 1x keep running in sleep |
| low_power | input | 1 | High while the chip is in power-down or green mode |
| sys_rst | output | 1 | System reset, active high |
| rst_cause | output | 2 | Cause of the last reset: 00 watchdog, 10 power, 11 pin |

## Verification
The directed patterns cover several distinct cases:
- An unserviced count, to time the overflow to the exact tick.
- Periodic key writes, which must keep reset away indefinitely.
- Wrong-key writes, which must leave the overflow time unchanged.
- Long sleep in each running mode, which separates the freeze behaviour from the keep-running behaviour.
- Disabled periods followed by enabling, which show the count restarting from zero.

A long constrained-random stretch follows. It mixes sparse ticks, key and non-key writes, sleep toggles, mode changes and pin and power resets. Its purpose is to separate the priorities between these events when they fall in the same cycle. Throughout, the reset output and cause code are compared every cycle with a bench model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PAUSE = 2'd1,
        ST_OFF   = 2'd2,
        ST_HOLD  = 2'd3
    } wd_state_t;

    localparam logic [1:0] CAUSE_WDOG = 2'b00;
    localparam logic [1:0] CAUSE_RSVD = 2'b01;
    localparam logic [1:0] CAUSE_PWR  = 2'b10;
    localparam logic [1:0] CAUSE_PIN  = 2'b11;

    localparam logic [1:0] MODE_OFF = 2'b00;

endpackage

// File: rtl/wdog_key.sv
module wdog_key #(
    parameter int unsigned    KEY_W = 8,
    parameter logic [KEY_W-1:0] KEY = 8'h5A
) (
    input  logic             clr_wr,
    input  logic [KEY_W-1:0] clr_data,
    output logic             key_hit
);
    always_comb begin
        key_hit = clr_wr && (clr_data == KEY);
    end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int unsigned W   = 6,
    parameter int unsigned TOP = 63
) (
    input  logic         clk,
    input  logic         por_rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         at_top
);
    localparam logic [W-1:0] TOP_V = W'(TOP);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or posedge por_rst) begin
        if (por_rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= (cnt_q == TOP_V) ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        cnt    = cnt_q;
        at_top = (cnt_q == TOP_V);
    end
endmodule

// File: rtl/wdog_cause.sv
module wdog_cause
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       por_rst,
    input  logic       ext_rst,
    input  logic       fire,
    output logic [1:0] cause
);
    logic [1:0] cause_q;

    always_ff @(posedge clk or posedge por_rst) begin
        if (por_rst) begin
            cause_q <= CAUSE_PWR;
        end else if (ext_rst) begin
            cause_q <= CAUSE_PIN;
        end else if (fire) begin
            cause_q <= CAUSE_WDOG;
        end
    end

    always_comb begin
        cause = cause_q;
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      por_rst,
    input  logic      ext_rst,
    input  logic      tick,
    input  logic      key_hit,
    input  logic      mode_off,
    input  logic      always_on,
    input  logic      low_power,
    input  logic      cnt_top,
    input  logic      hold_top,
    output wd_state_t state,
    output logic      fire,
    output logic      sys_rst
);
    wd_state_t state_q;
    wd_state_t state_d;
    wd_state_t resume_st;
    logic      freeze;
    logic      overflow;

    always_comb begin
        freeze   = low_power && !always_on;
        overflow = tick && cnt_top && !key_hit;
        if (mode_off) begin
            resume_st = ST_OFF;
        end else if (freeze) begin
            resume_st = ST_PAUSE;
        end else begin
            resume_st = ST_RUN;
        end
    end

    // state register
    always_ff @(posedge clk or posedge por_rst) begin
        if (por_rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (ext_rst) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (mode_off) begin
                        state_d = ST_OFF;
                    end else if (overflow) begin
                        state_d = ST_HOLD;
                    end else if (freeze) begin
                        state_d = ST_PAUSE;
                    end
                end
                ST_PAUSE: begin
                    if (mode_off) begin
                        state_d = ST_OFF;
                    end else if (!freeze) begin
                        state_d = ST_RUN;
                    end
                end
                ST_OFF: begin
                    if (!mode_off) begin
                        state_d = resume_st;
                    end
                end
                ST_HOLD: begin
                    if (tick && hold_top) begin
                        state_d = resume_st;
                    end
                end
                default: state_d = ST_HOLD;
            endcase
        end
    end

    // outputs
    always_comb begin
        state   = state_q;
        sys_rst = (state_q == ST_HOLD);
        fire    = (state_q == ST_RUN) && !ext_rst && !mode_off && overflow;
    end
endmodule

// File: rtl/wdog_rstcause.sv
module wdog_rstcause
    import wdog_pkg::*;
#(
    parameter int unsigned      CNT_W      = 6,
    parameter int unsigned      HOLD_TICKS = 4,
    parameter int unsigned      KEY_W      = 8,
    parameter logic [KEY_W-1:0] CLR_KEY    = 8'h5A
) (
    input  logic             clk,
    input  logic             por_rst,
    input  logic             ext_rst,
    input  logic             tick,
    input  logic             clr_wr,
    input  logic [KEY_W-1:0] clr_data,
    input  logic [1:0]       wd_mode,
    input  logic             low_power,
    output logic             sys_rst,
    output logic [1:0]       rst_cause
);
    localparam int unsigned CNT_TOP  = (1 << CNT_W) - 1;
    localparam int unsigned HOLD_W   = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam int unsigned HOLD_TOP = HOLD_TICKS - 1;

    wd_state_t         state;
    logic              key_hit;
    logic              mode_off;
    logic              always_on;
    logic              fire;
    logic [CNT_W-1:0]  wd_cnt;
    logic              cnt_top;
    logic              cnt_clr;
    logic              cnt_inc;
    logic [HOLD_W-1:0] hold_cnt;
    logic              hold_top;
    logic              hold_clr;
    logic              hold_inc;

    always_comb begin
        mode_off  = (wd_mode == MODE_OFF);
        always_on = wd_mode[1];
        cnt_clr   = ext_rst || key_hit || mode_off ||
                    (state == ST_OFF) || (state == ST_HOLD);
        cnt_inc   = tick && (state == ST_RUN);
        hold_clr  = ext_rst || (state != ST_HOLD);
        hold_inc  = tick;
    end

    wdog_key #(
        .KEY_W (KEY_W),
        .KEY   (CLR_KEY)
    ) u_key (
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .key_hit  (key_hit)
    );

    wdog_count #(
        .W   (CNT_W),
        .TOP (CNT_TOP)
    ) u_main_cnt (
        .clk     (clk),
        .por_rst (por_rst),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .cnt     (wd_cnt),
        .at_top  (cnt_top)
    );

    wdog_count #(
        .W   (HOLD_W),
        .TOP (HOLD_TOP)
    ) u_hold_cnt (
        .clk     (clk),
        .por_rst (por_rst),
        .clr     (hold_clr),
        .inc     (hold_inc),
        .cnt     (hold_cnt),
        .at_top  (hold_top)
    );

    wdog_fsm u_fsm (
        .clk       (clk),
        .por_rst   (por_rst),
        .ext_rst   (ext_rst),
        .tick      (tick),
        .key_hit   (key_hit),
        .mode_off  (mode_off),
        .always_on (always_on),
        .low_power (low_power),
        .cnt_top   (cnt_top),
        .hold_top  (hold_top),
        .state     (state),
        .fire      (fire),
        .sys_rst   (sys_rst)
    );

    wdog_cause u_cause (
        .clk     (clk),
        .por_rst (por_rst),
        .ext_rst (ext_rst),
        .fire    (fire),
        .cause   (rst_cause)
    );

    logic unused_hold;
    always_comb begin
        unused_hold = ^hold_cnt;
    end
endmodule

// File: rtl/wdog_rstcause_chk.sv
module wdog_rstcause_chk
    import wdog_pkg::*;
#(
    parameter int unsigned      CNT_W   = 6,
    parameter int unsigned      KEY_W   = 8,
    parameter logic [KEY_W-1:0] CLR_KEY = 8'h5A
) (
    input logic             clk,
    input logic             por_rst,
    input logic             ext_rst,
    input logic             tick,
    input logic             clr_wr,
    input logic [KEY_W-1:0] clr_data,
    input logic [1:0]       wd_mode,
    input logic             low_power,
    input logic             sys_rst,
    input logic [1:0]       rst_cause,
    input wd_state_t        state,
    input logic [CNT_W-1:0] wd_cnt
);
    logic good_key;
    logic unused_in;
    always_comb begin
        good_key  = clr_wr && (clr_data == CLR_KEY);
        unused_in = low_power;
    end

    p_never_rsvd_r2: assert property (@(posedge clk) disable iff (por_rst)
        rst_cause != CAUSE_RSVD);

    p_pin_cause_r3: assert property (@(posedge clk) disable iff (por_rst)
        ext_rst |=> (sys_rst && rst_cause == CAUSE_PIN && wd_cnt == '0));

    p_fire_r1: assert property (@(posedge clk) disable iff (por_rst)
        (state == ST_RUN && wd_mode != MODE_OFF && !ext_rst && tick &&
         !good_key && (&wd_cnt)) |=> (sys_rst && rst_cause == CAUSE_WDOG));

    p_pause_frozen_r4: assert property (@(posedge clk) disable iff (por_rst)
        (state == ST_PAUSE && wd_mode != MODE_OFF && !ext_rst && !good_key)
        |=> $stable(wd_cnt));

    p_key_restart_r6: assert property (@(posedge clk) disable iff (por_rst)
        (good_key && !sys_rst) |=> (wd_cnt == '0));

    p_bad_key_r7: assert property (@(posedge clk) disable iff (por_rst)
        (state == ST_RUN && !tick && !ext_rst && wd_mode != MODE_OFF &&
         clr_wr && clr_data != CLR_KEY) |=> $stable(wd_cnt));

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (por_rst)
        (state == ST_OFF) |-> (wd_cnt == '0 && !sys_rst));
endmodule

bind wdog_rstcause wdog_rstcause_chk #(
    .CNT_W   (CNT_W),
    .KEY_W   (KEY_W),
    .CLR_KEY (CLR_KEY)
) u_chk (
    .clk       (clk),
    .por_rst   (por_rst),
    .ext_rst   (ext_rst),
    .tick      (tick),
    .clr_wr    (clr_wr),
    .clr_data  (clr_data),
    .wd_mode   (wd_mode),
    .low_power (low_power),
    .sys_rst   (sys_rst),
    .rst_cause (rst_cause),
    .state     (state),
    .wd_cnt    (wd_cnt)
);

// File: tb/wdog_rstcause_test.sv
`timescale 1ns/1ps
module wdog_rstcause_test;
    localparam int       CNT_W      = 6;
    localparam int       HOLD_TICKS = 4;
    localparam int       LIMIT      = 1 << CNT_W;
    localparam bit [7:0] KEY        = 8'h5A;

    logic       clk = 1'b0;
    logic       por_rst = 1'b1;
    logic       ext_rst = 1'b0;
    logic       tick = 1'b0;
    logic       clr_wr = 1'b0;
    logic [7:0] clr_data = 8'h00;
    logic [1:0] wd_mode = 2'b01;
    logic       low_power = 1'b0;
    logic       sys_rst;
    logic [1:0] rst_cause;

    wdog_rstcause #(
        .CNT_W      (CNT_W),
        .HOLD_TICKS (HOLD_TICKS),
        .KEY_W      (8),
        .CLR_KEY    (KEY)
    ) uut (
        .clk       (clk),
        .por_rst   (por_rst),
        .ext_rst   (ext_rst),
        .tick      (tick),
        .clr_wr    (clr_wr),
        .clr_data  (clr_data),
        .wd_mode   (wd_mode),
        .low_power (low_power),
        .sys_rst   (sys_rst),
        .rst_cause (rst_cause)
    );

    always #5 clk = ~clk;

    // model state: 0 run, 1 pause, 2 off, 3 hold
    int       m_st = 3;
    int       m_cnt = 0;
    int       m_hold = 0;
    bit [1:0] m_cause = 2'b10;
    int       n_chk = 0;
    int       n_bad = 0;
    string    tag = "R10";
    bit       saw_rst = 1'b0;

    task automatic check(string rq, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit hit, off, slp;
        int nst;
        if (por_rst) begin
            m_st = 3; m_cnt = 0; m_hold = 0; m_cause = 2'b10;
            return;
        end
        hit = clr_wr && (clr_data == KEY);
        off = (wd_mode == 2'b00);
        slp = low_power && !wd_mode[1];
        nst = m_st;
        if (ext_rst) nst = 3;
        else begin
            case (m_st)
                0: if (off) nst = 2;
                   else if (tick && m_cnt == LIMIT-1 && !hit) nst = 3;
                   else if (slp) nst = 1;
                1: if (off) nst = 2; else if (!slp) nst = 0;
                2: if (!off) nst = slp ? 1 : 0;
                default: if (tick && m_hold == HOLD_TICKS-1) nst = off ? 2 : (slp ? 1 : 0);
            endcase
        end
        if (ext_rst) m_cause = 2'b11;
        else if (m_st == 0 && nst == 3) m_cause = 2'b00;
        if (m_st != 3 || ext_rst) m_hold = 0;
        else if (tick) m_hold = (m_hold == HOLD_TICKS-1) ? 0 : m_hold + 1;
        if (ext_rst || hit || off || m_st == 2 || m_st == 3) m_cnt = 0;
        else if (tick && m_st == 0) m_cnt = (m_cnt == LIMIT-1) ? 0 : m_cnt + 1;
        m_st = nst;
    endtask

    task automatic step();
        model_step();
        @(negedge clk);
        if (sys_rst) saw_rst = 1'b1;
        check(tag, {29'd0, sys_rst, rst_cause}, {29'd0, (m_st == 3), m_cause});
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_clr(bit [7:0] v);
        clr_wr = 1'b1; clr_data = v;
        step();
        clr_wr = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        // R10: power reset state
        tag = "R10";
        tick = 1'b1;
        run(3);
        check("R10", {30'd0, rst_cause}, 2);
        check("R10", {31'd0, sys_rst}, 1);
        por_rst = 1'b0;
        // R8: hold window after power reset
        tag = "R8";
        run(HOLD_TICKS - 1);
        check("R8", {31'd0, sys_rst}, 1);
        step();
        check("R8", {31'd0, sys_rst}, 0);
        // R1: overflow on exact tick
        tag = "R1";
        run(LIMIT - 1);
        check("R1", {31'd0, sys_rst}, 0);
        step();
        check("R1", {29'd0, sys_rst, rst_cause}, 4);
        run(HOLD_TICKS);
        // R6: periodic keyed clears keep reset away
        tag = "R6"; saw_rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            run(LIMIT - 10);
            write_clr(KEY);
        end
        check("R6", {31'd0, saw_rst}, 0);
        // R7: wrong keys ignored; overflow time unchanged
        tag = "R7"; saw_rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            run(9);
            write_clr(8'hA5 ^ 8'(i));
        end
        run(LIMIT - 61);
        check("R7", {31'd0, saw_rst}, 0);
        step();
        check("R7", {31'd0, sys_rst}, 1);
        run(HOLD_TICKS);
        // R4: stop-in-sleep mode freezes count
        tag = "R4"; saw_rst = 1'b0;
        run(30);
        low_power = 1'b1;
        run(300);
        check("R4", {31'd0, saw_rst}, 0);
        low_power = 1'b0;
        run(LIMIT - 31);
        check("R4", {31'd0, sys_rst}, 0);
        run(2);
        check("R4", {31'd0, sys_rst}, 1);
        run(HOLD_TICKS);
        // R5: keep-running mode resets from sleep
        tag = "R5"; saw_rst = 1'b0;
        wd_mode = 2'b10;
        low_power = 1'b1;
        run(LIMIT + 2);
        check("R5", {31'd0, saw_rst}, 1);
        check("R5", {30'd0, rst_cause}, 0);
        run(HOLD_TICKS + 10);
        wd_mode = 2'b11;
        write_clr(KEY);
        run(LIMIT + 1);
        low_power = 1'b0;
        run(HOLD_TICKS + 2);
        // R9: disabled never resets, enable restarts from zero
        tag = "R9"; saw_rst = 1'b0;
        wd_mode = 2'b00;
        run(300);
        check("R9", {31'd0, saw_rst}, 0);
        wd_mode = 2'b01;
        run(LIMIT);
        check("R9", {31'd0, sys_rst}, 0);
        run(2);
        check("R9", {31'd0, sys_rst}, 1);
        run(HOLD_TICKS + 3);
        // R3: external pin
        tag = "R3";
        run(20);
        ext_rst = 1'b1;
        run(5);
        check("R3", {29'd0, sys_rst, rst_cause}, 7);
        ext_rst = 1'b0;
        run(HOLD_TICKS + 1);
        check("R3", {31'd0, sys_rst}, 0);
        // R2: random mix
        tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            tick      = ($urandom % 2) == 0;
            clr_wr    = ($urandom % 8) == 0;
            clr_data  = (($urandom % 2) == 0) ? KEY : 8'($urandom);
            ext_rst   = ($urandom % 250) == 0;
            por_rst   = ($urandom % 1500) == 0;
            if (($urandom % 25) == 0) low_power = ~low_power;
            if (($urandom % 200) == 0) wd_mode = 2'($urandom);
            step();
            check("R2", {31'd0, rst_cause == 2'b01}, 0);
        end
        por_rst = 1'b0; ext_rst = 1'b0; clr_wr = 1'b0;
        run(4);
        summary();
        $finish;
    end
endmodule